// File: doc/BRIEF.md
# Prescaled Serial Clock Generator

This block derives the bit clock of a synchronous serial port, together with the per-bit shift and sample strobes, from a fast parent clock. The division ratio is the product of two stages. The first is a prescaler that divides by 1 to 32 and is programmed with the value minus one. The second is a power-of-two divider selected by a 3-bit code. While the block is enabled, a phase counter steps through one bit period of that many parent cycles. The serial clock sits at its idle level for the first half of the period and at the opposite level for the second half.

The idle level of the serial clock follows the clock-polarity input. The clock-phase input, combined with the polarity, decides which serial clock edge carries the launch strobe and which carries the capture strobe. Both strobes are single parent-cycle pulses. They are registered so that each appears in the same cycle as the serial clock edge it belongs to, which lets a transfer engine shift out and sample data without decoding the clock itself.

A build parameter sets the smallest allowed divider exponent. With a value of 1, the divide-by-one code is not available.

Top module: `sclk_gen`

## Requirements
- R1: While reset is asserted, `sck`, `sck_oe`, `launch` and `capture` are all low. On the cycle after `enable` is sampled low, `sck` equals `cpol`, `sck_oe` is low and no strobe is present.
- R2: `presc_code` holds the prescale factor P minus one, so codes 0 to 31 give P = 1 to 32.
- R3: `div_code` values 0, 1, 2, 3 and 4 select a divider D of 2, 4, 8, 16 and 32. Code 7 (all ones) selects D = 1.
- R4: The reserved `div_code` values 5 and 6 act as D = 32.
- R5: The bit period N is P × D parent cycles. Successive `capture` pulses are exactly N cycles apart.
- R6: With `MIN_DIV_POW` = 1, code 7 acts as D = 2 and all other codes keep their meaning. With `MIN_DIV_POW` = 0, code 7 is D = 1.
- R7: A combined ratio P × D of 1 is run as a ratio of 2.
- R8: Number the cycles after the first enabled clock edge k = 1, 2, and so on, with position k mod N. Positions below floor(N/2) show `sck` = `cpol`. The remaining positions show `sck` = not `cpol`.
- R9: The edge-select value e = `cpol` XOR (NOT `cpha`) names the `sck` edge that carries `launch`: 1 is the falling edge and 0 is the rising edge. `capture` rides on the other edge. As a result, with `cpha` = 0 `launch` marks position 0 and `capture` marks position floor(N/2); with `cpha` = 1 the two are swapped.
- R10: Each bit period holds exactly one `launch` and one `capture`, each one cycle wide. They never coincide, they alternate, and each appears in the cycle in which `sck` changes level.
- R11: `sck_oe` is high in the cycle after `enable` is sampled high and low in the cycle after it is sampled low. Each re-enable restarts the period count at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the serial clock while high |
| presc_code | input | PRESC_W | Prescale factor minus one |
| div_code | input | 3 | Power-of-two divider code |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Clock phase selecting the launch and capture edges |
| sck | output | 1 | Serial clock pin value |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| launch | output | 1 | One-cycle pulse on the edge that shifts out data |
| capture | output | 1 | One-cycle pulse on the edge that samples data |

## Verification
The bench targets the mapping of the non-linear divider code, including the all-ones divide-by-one code, the reserved codes and the minimum-exponent variant. A wrong decode shows up as a capture-to-capture spacing that does not equal P × D. Odd ratios and the degenerate ratio of one are exercised because an off-by-one half-period split, or a counter that never wraps, would skew the serial clock duty cycle or freeze it. All four polarity and phase combinations are run against a cycle-exact model. That model catches swapped launch and capture strobes, strobes one cycle away from their clock edge, and a serial clock that idles at the wrong level after disable.

// File: rtl/sclk_pkg.sv
`timescale 1ns/1ps
package sclk_pkg;
  localparam int DIV_W   = 3;
  localparam int MAX_POW = 5;

  // Divider code to exponent: 0..4 -> 1..5, 5/6 reserved -> 5, all ones -> 0
  function automatic logic [2:0] div_exponent(input logic [DIV_W-1:0] code);
    logic [2:0] e;
    if (code == '1)              e = 3'd0;
    else if (code > 3'd4)        e = 3'(MAX_POW);
    else                         e = code + 3'd1;
    return e;
  endfunction

  // 1 selects the falling serial clock edge for data launch
  function automatic logic launch_falls(input logic pol, input logic pha);
    return pol ^ ~pha;
  endfunction
endpackage

// File: rtl/sclk_ratio.sv
`timescale 1ns/1ps
module sclk_ratio #(
  parameter int PRESC_W     = 5,
  parameter int MIN_DIV_POW = 0,
  parameter int CNT_W       = PRESC_W + sclk_pkg::MAX_POW + 1
) (
  input  logic [PRESC_W-1:0]         presc_code,
  input  logic [sclk_pkg::DIV_W-1:0] div_code,
  output logic [CNT_W-1:0]           ratio,
  output logic [CNT_W-1:0]           half
);
  import sclk_pkg::*;

  logic [2:0]       pow_raw, pow_eff;
  logic [CNT_W-1:0] presc_val, ratio_raw;

  assign pow_raw = div_exponent(div_code);

  // R6: the variant parameter clamps the exponent from below
  generate
    if (MIN_DIV_POW > 0) begin : g_clamp
      assign pow_eff = (pow_raw < 3'(MIN_DIV_POW)) ? 3'(MIN_DIV_POW) : pow_raw;
    end else begin : g_free
      assign pow_eff = pow_raw;
    end
  endgenerate

  assign presc_val = CNT_W'(presc_code) + CNT_W'(1);   // R2
  assign ratio_raw = presc_val << pow_eff;              // R3 R4 R5

  // R7: a ratio of one cannot be split into two levels
  assign ratio = (ratio_raw < CNT_W'(2)) ? CNT_W'(2) : ratio_raw;
  assign half  = ratio >> 1;
endmodule

// File: rtl/sclk_phase_cnt.sv
`timescale 1ns/1ps
module sclk_phase_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] ratio,
  input  logic [CNT_W-1:0] half,
  output logic             lead_evt,
  output logic             trail_evt,
  output logic             upper_nx
);
  logic [CNT_W-1:0] pos_q, pos_inc, pos_nx;

  assign pos_inc = pos_q + CNT_W'(1);

  always_comb begin
    if (!run)                pos_nx = '0;   // R11 restart
    else if (pos_inc >= ratio) pos_nx = '0; // R5 wrap
    else                     pos_nx = pos_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_nx;
  end

  assign lead_evt  = run && (pos_nx == half);   // leaving idle level
  assign trail_evt = run && (pos_nx == '0);     // returning to idle level
  assign upper_nx  = run && (pos_nx >= half);   // R8

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(run) && ($past(pos_q) + CNT_W'(1) == $past(ratio)) |-> pos_q == '0) else $error("wrap"); // R5
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(run) && ($past(pos_q) < $past(ratio)) |-> pos_q < $past(ratio)) else $error("bound"); // R5
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(run) |-> pos_q == '0) else $error("restart"); // R11
endmodule

// File: rtl/sclk_edge_map.sv
`timescale 1ns/1ps
module sclk_edge_map (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cpol,
  input  logic cpha,
  input  logic lead_evt,
  input  logic trail_evt,
  input  logic upper_nx,
  output logic sck,
  output logic sck_oe,
  output logic launch,
  output logic capture
);
  import sclk_pkg::*;

  logic edge_sel, lead_launches;

  // R9: leading edge falls exactly when cpol is 1
  assign edge_sel      = launch_falls(cpol, cpha);
  assign lead_launches = (cpol == edge_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck     <= 1'b0;
      sck_oe  <= 1'b0;
      launch  <= 1'b0;
      capture <= 1'b0;
    end else begin
      sck     <= upper_nx ^ cpol;                      // R8
      sck_oe  <= run;                                   // R11
      launch  <= lead_launches ? lead_evt  : trail_evt; // R9
      capture <= lead_launches ? trail_evt : lead_evt;  // R9
    end
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(run) |-> !launch && !capture && !sck_oe && (sck == $past(cpol))) else $error("quiet"); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && capture)) else $error("excl"); // R10
  AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) && $past(run) && ($past(cpol) == $past(cpol, 2)) && (launch || capture)
      |-> sck != $past(sck)) else $error("edge"); // R10
  AST_LAUNCH_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) && launch && ($past(cpol) == $past(cpol, 2))
      |-> (sck == 1'b0) == launch_falls($past(cpol), $past(cpha))) else $error("dir"); // R9
endmodule

// File: rtl/sclk_gen.sv
`timescale 1ns/1ps
module sclk_gen #(
  parameter int PRESC_W     = 5,
  parameter int MIN_DIV_POW = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic [PRESC_W-1:0]         presc_code,
  input  logic [sclk_pkg::DIV_W-1:0] div_code,
  input  logic                       cpol,
  input  logic                       cpha,
  output logic                       sck,
  output logic                       sck_oe,
  output logic                       launch,
  output logic                       capture
);
  localparam int CNT_W = PRESC_W + sclk_pkg::MAX_POW + 1;

  logic [CNT_W-1:0] ratio, half;
  logic             lead_evt, trail_evt, upper_nx;

  sclk_ratio #(.PRESC_W(PRESC_W), .MIN_DIV_POW(MIN_DIV_POW), .CNT_W(CNT_W)) u_ratio (
    .presc_code(presc_code), .div_code(div_code), .ratio(ratio), .half(half));

  sclk_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(enable), .ratio(ratio), .half(half),
    .lead_evt(lead_evt), .trail_evt(trail_evt), .upper_nx(upper_nx));

  sclk_edge_map u_map (
    .clk(clk), .rst_n(rst_n), .run(enable), .cpol(cpol), .cpha(cpha),
    .lead_evt(lead_evt), .trail_evt(trail_evt), .upper_nx(upper_nx),
    .sck(sck), .sck_oe(sck_oe), .launch(launch), .capture(capture));

  // Strobe order tracker for the alternation checks
  logic seen_q, last_launch_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0; last_launch_q <= 1'b0;
    end else if (!enable) begin
      seen_q <= 1'b0;
    end else if (launch || capture) begin
      seen_q <= 1'b1; last_launch_q <= launch;
    end
  end

  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ratio >= CNT_W'(2)) else $error("floor"); // R7
  AST_MIN_POW_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (MIN_DIV_POW == 0) || !ratio[0]) else $error("minpow"); // R6
  AST_ALT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && launch |-> !last_launch_q) else $error("alt l"); // R10
  AST_ALT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && capture |-> last_launch_q) else $error("alt c"); // R10
endmodule

// File: tb/sclk_gen_test.sv
`timescale 1ns/1ps
module sclk_gen_test;
  localparam int PW = 5;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [PW-1:0] presc_code = '0;
  logic [2:0]    div_code = '0;
  logic [1:0]    sck, oe, lau, cap;
  int n_checks = 0, n_errors = 0;

  always #2.5 clk = ~clk;

  sclk_gen uut (.clk(clk), .rst_n(rst_n), .enable(enable), .presc_code(presc_code),
    .div_code(div_code), .cpol(cpol), .cpha(cpha), .sck(sck[0]), .sck_oe(oe[0]),
    .launch(lau[0]), .capture(cap[0]));
  sclk_gen #(.MIN_DIV_POW(1)) uut_m1 (.clk(clk), .rst_n(rst_n), .enable(enable),
    .presc_code(presc_code), .div_code(div_code), .cpol(cpol), .cpha(cpha),
    .sck(sck[1]), .sck_oe(oe[1]), .launch(lau[1]), .capture(cap[1]));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected total ratio, written as a lookup on the divider code
  function automatic int exp_ratio(input int p, input int d, input int minp);
    int f, r;
    case (d)
      7:       f = (minp == 1) ? 2 : 1;
      5, 6:    f = 32;
      default: f = 1 << (d + 1);
    endcase
    r = (p + 1) * f;
    return (r == 1) ? 2 : r;
  endfunction

  task automatic run_scn(input string tag, input int p, input int d, input bit pol, input bit pha);
    int n[2], first_cap[2], per[2], bad_s[2], bad_l[2], bad_c[2], bad_o[2];
    int len;
    for (int i = 0; i < 2; i++) begin
      n[i] = exp_ratio(p, d, i); first_cap[i] = -1; per[i] = -1;
      bad_s[i] = 0; bad_l[i] = 0; bad_c[i] = 0; bad_o[i] = 0;
    end
    len = 2 * ((n[0] > n[1]) ? n[0] : n[1]) + 4;
    @(negedge clk);
    enable = 1'b0; presc_code = p[PW-1:0]; div_code = d[2:0]; cpol = pol; cpha = pha;
    @(negedge clk);
    for (int i = 0; i < 2; i++)
      check(sck[i] == pol && !oe[i] && !lau[i] && !cap[i], "R1", "idle level", int'(sck[i]), int'(pol));
    enable = 1'b1;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        int ph = k % n[i];
        bit up = (ph >= n[i] / 2);
        bit ld = (ph == n[i] / 2);
        bit tr = (ph == 0);
        if (sck[i] != (up ^ pol))             bad_s[i]++;
        if (lau[i] != (pha ? ld : tr))        bad_l[i]++;
        if (cap[i] != (pha ? tr : ld))        bad_c[i]++;
        if (oe[i] != 1'b1)                    bad_o[i]++;
        if (cap[i]) begin
          if (first_cap[i] < 0) first_cap[i] = k;
          else if (per[i] < 0)  per[i] = k - first_cap[i];
        end
      end
    end
    for (int i = 0; i < 2; i++) begin
      check(bad_s[i] == 0, "R8", "sck mismatches", bad_s[i], 0);
      check(bad_l[i] == 0, "R9", "launch mismatches", bad_l[i], 0);
      check(bad_c[i] == 0, "R10", "capture mismatches", bad_c[i], 0);
      check(bad_o[i] == 0, "R11", "oe low while running", bad_o[i], 0);
      check(per[i] == n[i], (i == 1 && d == 7) ? "R6" : tag, "capture spacing", per[i], n[i]);
    end
    enable = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 2; i++)
      check(sck[i] == pol && !oe[i] && !lau[i] && !cap[i], "R11", "after disable", int'(oe[i]), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL R5 watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++)
      check(!sck[i] && !oe[i] && !lau[i] && !cap[i], "R1", "in reset", int'(sck[i]), 0);
    rst_n = 1'b1;
    run_scn("R7", 0, 7, 0, 0);
    for (int d = 0; d < 5; d++) run_scn("R3", 0, d, d[0], d[1]);
    run_scn("R3", 1, 7, 1, 1);
    run_scn("R4", 0, 5, 0, 1);
    run_scn("R4", 1, 6, 1, 0);
    run_scn("R2", 31, 7, 0, 0);
    run_scn("R2", 31, 4, 1, 1);
    run_scn("R2", 2, 7, 1, 0);
    run_scn("R2", 4, 1, 0, 1);
    for (int m = 0; m < 4; m++) run_scn("R9", 2, 0, m[1], m[0]);
    for (int r = 0; r < 20; r++)
      run_scn("R5", int'($urandom % 16), int'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2));
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule